// File: doc/BRIEF.md
# Event-Driven GPIO Output Action Unit

This block owns a 32-bit general-purpose output register and lets four independent event channels modify single bits of it without software involvement. Each channel is set up by one byte of a 32-bit configuration register: an enable, a two-bit action and a five-bit target pin. When an enabled channel sees an event strobe, the selected output bit is loaded with the event's level, forced high, forced low or inverted on the next clock edge.

Both registers are reachable through a minimal register bus with a one-bit address, a write enable and a combinational read path. The 32 output lines always show the output register. Collisions are resolved deterministically: among channels hitting the same pin the highest-numbered one wins, and any event action beats a bus write on the bit it touches.

Top module: `evgpio_unit`

## Requirements
- R1: On synchronous active-high reset the configuration register and the output register both become zero, so all channels are disabled and gpio_out is zero.
- R2: Bus address 0 selects the configuration register and address 1 the output register; a write with bus_we high loads bus_wdata on the clock edge, bus_rdata shows the addressed register combinationally, and gpio_out always equals the output register.
- R3: A channel whose enable bit is 0 changes no output bit, whatever its strobe, level, action or pin.
- R4: Action code 0 loads the channel's ev_level bit into the selected output bit.
- R5: Action code 1 sets the selected output bit to 1 and action code 2 clears it to 0.
- R6: Action code 3 inverts the selected output bit relative to its value before the clock edge.
- R7: Channel x is configured by bits [8x+7:8x]; within the byte bit 7 is the enable, bits 6:5 the action code and bits 4:0 the pin index; the action appears on gpio_out after the first rising edge that samples the strobe, not earlier, using the configuration held before that edge.
- R8: When several enabled channels strobe the same pin in one cycle the highest-numbered channel decides its value; strobes on distinct pins in the same cycle are all applied.
- R9: A bus write to the output register in the same cycle as an event action takes bus_wdata for every bit except those touched by the event, which take the event's result.
- R10: Enabled channels without a strobe, and pins that no strobing channel selects, keep their value; over long random sequences every output bit matches a model built from R1 to R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Register select: 0 configuration, 1 output |
| bus_we | input | 1 | Write enable for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed register |
| ev_strobe | input | 4 | One-cycle event strobe per channel |
| ev_level | input | 4 | Level accompanying each channel's strobe |
| gpio_out | output | 32 | Output register value |

## Verification
The properties assume each strobe is a one-cycle pulse sampled on a rising edge and that bus inputs are steady around that edge; they track channel 3 alone for the per-action checks because nothing can outrank it on its pin. The bench drives every input on the falling edge and lowers strobes and write enables one cycle later, so every pulse lasts exactly one sampling edge. Random runs mix configuration writes, output writes and multi-channel events in the same cycle, staying within that pulse discipline.

// File: rtl/evgpio_pkg.sv
package evgpio_pkg;

    localparam int NUM_CH   = 4;
    localparam int PIN_W    = 5;
    localparam int DATA_W   = 1 << PIN_W;
    localparam int SLOT_W   = 8;
    localparam int CFG_W    = NUM_CH * SLOT_W;

    localparam logic ADDR_CFG = 1'b0;
    localparam logic ADDR_OUT = 1'b1;

    typedef enum logic [1:0] {
        ACT_DRIVE = 2'd0,
        ACT_SET   = 2'd1,
        ACT_CLR   = 2'd2,
        ACT_FLIP  = 2'd3
    } act_e;

    typedef struct packed {
        logic             en;
        act_e             act;
        logic [PIN_W-1:0] pin;
    } chan_cfg_t;

    function automatic logic act_result(act_e a, logic level, logic cur);
        logic r;
        case (a)
            ACT_DRIVE: r = level;
            ACT_SET:   r = 1'b1;
            ACT_CLR:   r = 1'b0;
            default:   r = ~cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/evgpio_cfg_reg.sv
module evgpio_cfg_reg #(
    parameter int CFG_W = evgpio_pkg::CFG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= wdata;
        end
    end
endmodule

// File: rtl/evgpio_chan_decode.sv
module evgpio_chan_decode
    import evgpio_pkg::*;
#(
    parameter int DATA_W = evgpio_pkg::DATA_W
) (
    input  chan_cfg_t         cfg,
    input  logic              strobe,
    input  logic              level,
    input  logic [DATA_W-1:0] cur,
    output logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] val
);
    logic              hit;
    logic [DATA_W-1:0] onehot;
    logic              new_bit;

    always_comb begin
        hit     = strobe & cfg.en;
        onehot  = hit ? (DATA_W'(1) << cfg.pin) : '0;
        new_bit = act_result(cfg.act, level, cur[cfg.pin]);
        mask    = onehot;
        val     = new_bit ? onehot : '0;
    end
endmodule

// File: rtl/evgpio_merge.sv
module evgpio_merge #(
    parameter int NUM_CH = evgpio_pkg::NUM_CH,
    parameter int DATA_W = evgpio_pkg::DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_we,
    input  logic [DATA_W-1:0]        bus_wdata,
    input  logic [NUM_CH*DATA_W-1:0] masks,
    input  logic [NUM_CH*DATA_W-1:0] vals,
    output logic [DATA_W-1:0]        out_q
);
    logic [DATA_W-1:0] nxt;

    // Later channels overwrite earlier ones: highest index wins a shared pin.
    always_comb begin
        nxt = bus_we ? bus_wdata : out_q;
        for (int c = 0; c < NUM_CH; c++) begin
            nxt = (nxt & ~masks[c*DATA_W +: DATA_W]) | vals[c*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= nxt;
        end
    end
endmodule

// File: rtl/evgpio_unit.sv
module evgpio_unit
    import evgpio_pkg::*;
#(
    parameter int NUM_CH = evgpio_pkg::NUM_CH,
    parameter int DATA_W = evgpio_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] ev_strobe,
    input  logic [NUM_CH-1:0] ev_level,
    output logic [DATA_W-1:0] gpio_out
);
    localparam int SLOT  = $bits(chan_cfg_t);
    localparam int CFGW  = NUM_CH * SLOT;

    logic [CFGW-1:0]          cfg_q;
    logic [DATA_W-1:0]        out_q;
    logic [NUM_CH*DATA_W-1:0] masks;
    logic [NUM_CH*DATA_W-1:0] vals;
    logic                     cfg_we;
    logic                     out_we;

    assign cfg_we = bus_we && (bus_addr == ADDR_CFG);
    assign out_we = bus_we && (bus_addr == ADDR_OUT);

    evgpio_cfg_reg #(.CFG_W(CFGW)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (bus_wdata[CFGW-1:0]),
        .cfg_q (cfg_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        evgpio_chan_decode #(.DATA_W(DATA_W)) u_dec (
            .cfg    (chan_cfg_t'(cfg_q[c*SLOT +: SLOT])),
            .strobe (ev_strobe[c]),
            .level  (ev_level[c]),
            .cur    (out_q),
            .mask   (masks[c*DATA_W +: DATA_W]),
            .val    (vals[c*DATA_W +: DATA_W])
        );
    end

    evgpio_merge #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_merge (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (out_we),
        .bus_wdata (bus_wdata),
        .masks     (masks),
        .vals      (vals),
        .out_q     (out_q)
    );

    assign bus_rdata = (bus_addr == ADDR_OUT) ? out_q : DATA_W'(cfg_q);
    assign gpio_out  = out_q;
endmodule

// File: rtl/evgpio_unit_chk.sv
module evgpio_unit_chk
    import evgpio_pkg::*;
#(
    parameter int NUM_CH = evgpio_pkg::NUM_CH,
    parameter int DATA_W = evgpio_pkg::DATA_W
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       bus_addr,
    input logic                       bus_we,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic [NUM_CH-1:0]          ev_strobe,
    input logic [NUM_CH-1:0]          ev_level,
    input logic [DATA_W-1:0]          gpio_out,
    input logic [NUM_CH*$bits(chan_cfg_t)-1:0] cfg_q
);
    localparam int SLOT = $bits(chan_cfg_t);

    chan_cfg_t         top_cfg;
    logic [NUM_CH-1:0] en_vec;
    logic              any_hit;
    logic              top_hit;
    logic              out_wr;
    logic [PIN_W-1:0]  pin_q;
    logic              bit_q;
    logic              level_q;
    logic              rst_q;

    assign top_cfg = chan_cfg_t'(cfg_q[(NUM_CH-1)*SLOT +: SLOT]);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_en
        assign en_vec[c] = cfg_q[c*SLOT + SLOT - 1];
    end
    assign any_hit = |(ev_strobe & en_vec);
    assign top_hit = ev_strobe[NUM_CH-1] && top_cfg.en;
    assign out_wr  = bus_we && (bus_addr == ADDR_OUT);

    always_ff @(posedge clk) begin
        pin_q   <= top_cfg.pin;
        bit_q   <= gpio_out[top_cfg.pin];
        level_q <= ev_level[NUM_CH-1];
        rst_q   <= rst;
    end

    always_ff @(posedge clk) begin
        if (rst_q) begin
            p_reset_zero_r1: assert (gpio_out == '0);
        end
    end

    p_bus_write_r2: assert property (@(posedge clk) disable iff (rst)
        (out_wr && !any_hit) |=> (gpio_out == $past(bus_wdata)));

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!out_wr && !any_hit) |=> $stable(gpio_out));

    p_top_drive_r4: assert property (@(posedge clk) disable iff (rst)
        (top_hit && top_cfg.act == ACT_DRIVE) |=> (gpio_out[pin_q] == level_q));

    p_top_set_r5: assert property (@(posedge clk) disable iff (rst)
        (top_hit && top_cfg.act == ACT_SET) |=> gpio_out[pin_q]);

    p_top_clr_r5: assert property (@(posedge clk) disable iff (rst)
        (top_hit && top_cfg.act == ACT_CLR) |=> !gpio_out[pin_q]);

    p_top_flip_r6: assert property (@(posedge clk) disable iff (rst)
        (top_hit && top_cfg.act == ACT_FLIP) |=> (gpio_out[pin_q] != bit_q));
endmodule

bind evgpio_unit evgpio_unit_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .ev_strobe (ev_strobe),
    .ev_level  (ev_level),
    .gpio_out  (gpio_out),
    .cfg_q     (cfg_q)
);

// File: tb/tb_evgpio_unit.sv
`timescale 1ns/1ps
module tb_evgpio_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_addr = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  ev_strobe = '0;
    logic [3:0]  ev_level = '0;
    logic [31:0] gpio_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] cfg_m = '0;
    logic [31:0] out_m = '0;

    always #4 clk = ~clk;

    evgpio_unit dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_strobe(ev_strobe), .ev_level(ev_level), .gpio_out(gpio_out)
    );

    function automatic logic [7:0] slot(logic en, logic [1:0] act, logic [4:0] pin);
        return {en, act, pin};
    endfunction

    function automatic logic [31:0] model(logic [31:0] cur, logic [31:0] cfg, logic wr_out,
                                          logic [31:0] wd, logic [3:0] st, logic [3:0] lv);
        logic [31:0] n;
        n = wr_out ? wd : cur;
        for (int c = 0; c < 4; c++) begin
            logic [7:0] b;
            b = cfg[8*c +: 8];
            if (st[c] && b[7]) begin
                case (b[6:5])
                    2'd0: n[b[4:0]] = lv[c];
                    2'd1: n[b[4:0]] = 1'b1;
                    2'd2: n[b[4:0]] = 1'b0;
                    default: n[b[4:0]] = ~cur[b[4:0]];
                endcase
            end
        end
        return n;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: inputs applied at falling edge, result visible at next falling edge.
    task automatic step(logic we, logic addr, logic [31:0] wd, logic [3:0] st, logic [3:0] lv);
        logic [31:0] nout, ncfg;
        bus_we = we; bus_addr = addr; bus_wdata = wd; ev_strobe = st; ev_level = lv;
        nout = model(out_m, cfg_m, we && addr, wd, st, lv);
        ncfg = (we && !addr) ? wd : cfg_m;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; ev_strobe = '0; ev_level = '0;
        out_m = nout; cfg_m = ncfg;
    endtask

    task automatic rd(logic addr, output logic [31:0] d);
        bus_addr = addr;
        #1;
        d = bus_rdata;
    endtask

    task automatic wcfg(logic [31:0] v); step(1'b1, 1'b0, v, 4'h0, 4'h0); endtask
    task automatic wout(logic [31:0] v); step(1'b1, 1'b1, v, 4'h0, 4'h0); endtask

    task automatic t_reset();
        logic [31:0] d;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cfg_m = '0; out_m = '0;
        chk("R1 gpio after reset", gpio_out, 32'h0);
        rd(1'b0, d); chk("R1 cfg after reset", d, 32'h0);
        rd(1'b1, d); chk("R1 out after reset", d, 32'h0);
        step(1'b0, 1'b0, '0, 4'hF, 4'hF);
        chk("R1 channels disabled after reset", gpio_out, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wout(32'hA5A5_3C3C);
        chk("R2 gpio after out write", gpio_out, 32'hA5A5_3C3C);
        rd(1'b1, d); chk("R2 out readback", d, 32'hA5A5_3C3C);
        wcfg(32'h7F1E_6503);
        rd(1'b0, d); chk("R2 cfg readback", d, 32'h7F1E_6503);
        chk("R2 cfg write leaves gpio", gpio_out, 32'hA5A5_3C3C);
    endtask

    task automatic t_disabled();
        wout(32'h0000_00F0);
        wcfg({slot(0, 2'd1, 5'd0), slot(0, 2'd2, 5'd4), slot(0, 2'd3, 5'd5), slot(0, 2'd0, 5'd6)});
        step(1'b0, 1'b0, '0, 4'hF, 4'h0);
        chk("R3 disabled channels ignored", gpio_out, 32'h0000_00F0);
    endtask

    task automatic t_drive();
        wout(32'h0);
        wcfg({24'h0, slot(0, 2'd0, 5'd0)} | {16'h0, slot(1, 2'd0, 5'd9), 8'h0});
        step(1'b0, 1'b0, '0, 4'b0010, 4'b0010);
        chk("R4 drive level 1", gpio_out, 32'h0000_0200);
        step(1'b0, 1'b0, '0, 4'b0010, 4'b0000);
        chk("R4 drive level 0", gpio_out, 32'h0000_0000);
    endtask

    task automatic t_set_clr();
        wout(32'h0000_0001);
        wcfg({8'h0, slot(1, 2'd2, 5'd0), 8'h0, slot(1, 2'd1, 5'd31)});
        step(1'b0, 1'b0, '0, 4'b0001, 4'b0000);
        chk("R5 set pin 31", gpio_out, 32'h8000_0001);
        step(1'b0, 1'b0, '0, 4'b0100, 4'b1111);
        chk("R5 clear pin 0", gpio_out, 32'h8000_0000);
    endtask

    task automatic t_toggle();
        wout(32'h0);
        wcfg({slot(1, 2'd3, 5'd17), 24'h0});
        step(1'b0, 1'b0, '0, 4'b1000, 4'b0000);
        chk("R6 toggle to 1", gpio_out, 32'h0002_0000);
        step(1'b0, 1'b0, '0, 4'b1000, 4'b1000);
        chk("R6 toggle to 0", gpio_out, 32'h0000_0000);
    endtask

    task automatic t_layout();
        wout(32'h0);
        wcfg({slot(1, 2'd1, 5'd28), slot(1, 2'd1, 5'd20), slot(1, 2'd1, 5'd12), slot(1, 2'd1, 5'd4)});
        ev_strobe = 4'b0100;
        #1;
        chk("R7 no change before edge", gpio_out, 32'h0);
        ev_strobe = 4'b0000;
        step(1'b0, 1'b0, '0, 4'b0100, 4'b0000);
        chk("R7 byte 2 drives pin 20", gpio_out, 32'h0010_0000);
        // Config rewritten in the same cycle as a strobe: old config applies.
        step(1'b1, 1'b0, 32'h0, 4'b0001, 4'b0000);
        chk("R7 old config used on write cycle", gpio_out, 32'h0010_0010);
    endtask

    task automatic t_conflict();
        wout(32'h0000_0020);
        wcfg({slot(1, 2'd2, 5'd5), slot(1, 2'd1, 5'd5), slot(1, 2'd2, 5'd5), slot(1, 2'd1, 5'd5)});
        step(1'b0, 1'b0, '0, 4'b1111, 4'b0000);
        chk("R8 channel 3 clear wins", gpio_out, 32'h0000_0000);
        step(1'b0, 1'b0, '0, 4'b0111, 4'b0000);
        chk("R8 channel 2 set wins", gpio_out, 32'h0000_0020);
        wcfg({slot(1, 2'd1, 5'd30), slot(1, 2'd3, 5'd2), slot(1, 2'd1, 5'd8), slot(1, 2'd2, 5'd5)});
        step(1'b0, 1'b0, '0, 4'b1111, 4'b0000);
        chk("R8 distinct pins all applied", gpio_out, 32'h4000_0104);
    endtask

    task automatic t_bus_race();
        wout(32'h0);
        wcfg({16'h0, slot(1, 2'd1, 5'd7), slot(1, 2'd2, 5'd9)});
        step(1'b1, 1'b1, 32'h0000_FF00, 4'b0011, 4'b0000);
        chk("R9 event beats bus write", gpio_out, 32'h0000_FD80);
    endtask

    task automatic t_random();
        wcfg({slot(1, 2'd1, 5'd3), slot(1, 2'd3, 5'd11), slot(1, 2'd0, 5'd22), slot(1, 2'd2, 5'd30)});
        wout(32'h5555_AAAA);
        step(1'b0, 1'b0, '0, 4'b0000, 4'b1111);
        chk("R10 enabled channels without strobe hold", gpio_out, 32'h5555_AAAA);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            logic [31:0] d;
            r = $urandom;
            step(r[3:0] == 4'h0, r[4], $urandom, r[11:8], r[15:12]);
            chk("R10 random gpio vs model", gpio_out, out_m);
            rd(1'b0, d);
            chk("R10 random cfg vs model", d, cfg_m);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_regs();
        t_disabled();
        t_drive();
        t_set_clr();
        t_toggle();
        t_layout();
        t_conflict();
        t_bus_race();
        t_random();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule